// File: doc/BRIEF.md
# Seconds/Minutes/Hours/Day Counter with Alarm and Rate Flags

The block is a real-time clock with a 16-bit register port. It runs on a single low-frequency reference clock. Time is kept as three separate counters: seconds (0..59), a packed hour/minute value (hours 0..23, minutes 0..59) and a free-running 16-bit day count. It has no month or year handling. A control register turns counting on and tells the block which of three crystal rates drives it. A fractional prescaler then derives exactly one seconds tick per second from that rate, and also derives evenly spaced sub-second events at 2 Hz through 512 Hz.

Each event sets a sticky flag in a status register. Software clears a flag by writing a 1 to its bit. An enable register chooses which flags drive the interrupt line. A separate set of alarm registers holds a day, hour, minute and second. The alarm flag sets when the running time reaches all four values. Software reads and writes all of this through a simple synchronous port: byte-offset address, write strobe, write data, and combinational read data.

Top module: `rtc_core`

## Requirements
- R1: Register offsets: 0x00 hour/minute (hour in bits 12:8, minute in 5:0), 0x04 seconds (bits 5:0), 0x08 alarm hour/minute (same packing), 0x0C alarm seconds, 0x10 control, 0x14 status, 0x18 enable (all 16 bits kept), 0x20 day, 0x24 alarm day (16 bits each). Unimplemented bits read 0.
- R2: On each seconds tick, seconds step 0..59. A wrap carries into minutes (0..59), a minute wrap carries into hours (0..23), and an hour wrap increments the day counter.
- R3: Control bits 6:5 select the reference rate: 1 means 32000 Hz, 2 means 38400 Hz, and 0 or 3 mean 32768 Hz. For each setting, a seconds tick occurs exactly once every 32768, 32000 or 38400 clocks respectively.
- R4: Control bit 7 enables counting and reads back as written. While it is 0, the time counters and the prescaler stay frozen and no rate flags set.
- R5: A write to seconds, hour/minute or day loads the value on that edge and restarts the prescaler. A control write also restarts it. The next seconds update lands exactly one full second of clocks after the write edge.
- R6: Status bit layout: bit 4 is the 1 Hz flag, bit 7 the 2 Hz flag, and bits 8..15 are the 4, 8, 16, 32, 64, 128, 256 and 512 Hz flags. In 32768 Hz mode, the 512 Hz flag first sets 64 clocks after a restart and the 256 Hz flag first sets 128 clocks after it. Every flag sets on a whole-second boundary. Bits 0, 1, 3, 5 and 6 never set.
- R7: Writing a 1 to a status bit clears it, and writing 0 leaves it alone. If an event and a clear hit the same edge, the event wins.
- R8: The interrupt output is high whenever some status bit and its enable bit are both 1. Flags set whether or not they are enabled.
- R9: Alarm status bit 2 sets one clock after a seconds update leaves day, hour, minute and second equal to the alarm registers. It is set only on that single edge: if cleared while the time still matches, it stays clear.
- R10: Reads of unmapped offsets (for example 0x1C and 0x28) return 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock (32768, 32000 or 38400 Hz) |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_we | input | 1 | Write strobe, acts on the rising clock edge |
| bus_addr | input | ADDR_W (6) | Byte offset of the register |
| bus_wdata | input | DATA_W (16) | Write data |
| bus_rdata | output | DATA_W (16) | Read data for bus_addr (combinational) |
| irq_o | output | 1 | Interrupt request, level |

## Verification
Register writes take effect on the write edge, and reads are combinational, so the bench reads back half a cycle after each write edge. The bench counts edges from the edge that restarts the prescaler. It samples seconds, minute, hour, day and the tick flags one cycle before and one cycle after the exact edge the divisor predicts: edge 32768, 32000 or 38400, or edge 64 and 128 for the fast flags. The alarm flag is due one edge after the seconds update, and the bench brackets it the same way. The interrupt line follows status and enable within the same cycle, so it is sampled right after the write that changes either one.

// File: rtl/rtc_pkg.sv
// rtc_pkg: shared constants and the time-of-day record for the RTC.
// Assumes 6-bit byte offsets and a 16-bit data bus.
package rtc_pkg;

    localparam logic [5:0] OFS_HM   = 6'h00;
    localparam logic [5:0] OFS_SEC  = 6'h04;
    localparam logic [5:0] OFS_AHM  = 6'h08;
    localparam logic [5:0] OFS_ASEC = 6'h0C;
    localparam logic [5:0] OFS_CTRL = 6'h10;
    localparam logic [5:0] OFS_STAT = 6'h14;
    localparam logic [5:0] OFS_IEN  = 6'h18;
    localparam logic [5:0] OFS_DAY  = 6'h20;
    localparam logic [5:0] OFS_ADAY = 6'h24;

    localparam int STAT_ALARM     = 2;
    localparam int STAT_1HZ       = 4;
    localparam int STAT_2HZ       = 7;
    localparam int STAT_SAMPLE_LO = 8;

    localparam logic [5:0] SEC_LAST  = 6'd59;
    localparam logic [5:0] MIN_LAST  = 6'd59;
    localparam logic [4:0] HOUR_LAST = 5'd23;

    typedef struct packed {
        logic [4:0] hour;
        logic [5:0] min;
        logic [5:0] sec;
    } tod_t;

endpackage

// File: rtl/rtc_prescaler.sv
// rtc_prescaler: fractional divider from the reference clock to 2^SUB_W
// sub-second steps per second. rate_tick_o[k] pulses at 2^k Hz
// (k=0 is the seconds tick). Assumes restart_i is pulsed on any
// change of sel_i, so the accumulator never exceeds the new divisor.
module rtc_prescaler #(
    parameter int DIV_A = 32768,
    parameter int DIV_B = 32000,
    parameter int DIV_C = 38400,
    parameter int SUB_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic             restart_i,
    input  logic [1:0]       sel_i,
    output logic [SUB_W:0]   rate_tick_o
);
    localparam int DMAX_AB = (DIV_A > DIV_B) ? DIV_A : DIV_B;
    localparam int DMAX    = (DMAX_AB > DIV_C) ? DMAX_AB : DIV_C;
    localparam int ACC_W   = $clog2(DMAX) + 1;
    localparam int STEP    = 1 << SUB_W;

    logic [ACC_W-1:0] acc_q, div, sum;
    logic [SUB_W-1:0] sub_q;
    logic             ovf;

    // Pick the divisor for the selected reference rate.
    always_comb begin
        case (sel_i)
            2'd1:    div = ACC_W'(DIV_B);
            2'd2:    div = ACC_W'(DIV_C);
            default: div = ACC_W'(DIV_A);
        endcase
    end

    assign sum = acc_q + ACC_W'(STEP);
    assign ovf = en_i && !restart_i && (sum >= div);

    // Accumulate STEP per clock modulo div, and count the sub-second steps.
    always_ff @(posedge clk) begin
        if (!rst_n || restart_i) begin
            acc_q <= '0;
            sub_q <= '0;
        end else if (en_i) begin
            if (ovf) begin
                acc_q <= sum - div;
                sub_q <= sub_q + 1'b1;
            end else begin
                acc_q <= sum;
            end
        end
    end

    // Rate 2^k fires when the low SUB_W-k step bits wrap.
    for (genvar k = 0; k <= SUB_W; k++) begin : g_rate
        if (k < SUB_W) begin : g_div
            assign rate_tick_o[k] = ovf && (&sub_q[SUB_W-1-k:0]);
        end else begin : g_top
            assign rate_tick_o[k] = ovf;
        end
    end

    // R3
    acc_lt_div_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc_q < div);
endmodule

// File: rtl/rtc_timekeeper.sv
// rtc_timekeeper: seconds/minutes/hours/day counters with carries.
// A load strobe has priority over the tick; the top module never
// presents both in one cycle because a load restarts the prescaler.
module rtc_timekeeper
    import rtc_pkg::*;
#(
    parameter int DAY_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             ld_sec_i,
    input  logic             ld_hm_i,
    input  logic             ld_day_i,
    input  tod_t             load_i,
    input  logic [DAY_W-1:0] day_d_i,
    output tod_t             tod_o,
    output logic [DAY_W-1:0] day_o
);
    logic [5:0]       sec_q, min_q;
    logic [4:0]       hour_q;
    logic [DAY_W-1:0] day_q;
    logic             sec_wrap, min_wrap, hour_wrap;

    assign sec_wrap  = sec_q >= SEC_LAST;
    assign min_wrap  = min_q >= MIN_LAST;
    assign hour_wrap = hour_q >= HOUR_LAST;

    // Seconds: load or step, wrapping at the last value.
    always_ff @(posedge clk) begin
        if (!rst_n)        sec_q <= '0;
        else if (ld_sec_i) sec_q <= load_i.sec;
        else if (tick_i)   sec_q <= sec_wrap ? 6'd0 : sec_q + 6'd1;
    end

    // Minutes and hours: load together, step on carries.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            min_q  <= '0;
            hour_q <= '0;
        end else if (ld_hm_i) begin
            min_q  <= load_i.min;
            hour_q <= load_i.hour;
        end else if (tick_i && sec_wrap) begin
            min_q <= min_wrap ? 6'd0 : min_q + 6'd1;
            if (min_wrap) hour_q <= hour_wrap ? 5'd0 : hour_q + 5'd1;
        end
    end

    // Day counter: load or step on an hour wrap.
    always_ff @(posedge clk) begin
        if (!rst_n)        day_q <= '0;
        else if (ld_day_i) day_q <= day_d_i;
        else if (tick_i && sec_wrap && min_wrap && hour_wrap) day_q <= day_q + 1'b1;
    end

    assign tod_o = '{hour: hour_q, min: min_q, sec: sec_q};
    assign day_o = day_q;

    // R2
    sec_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_i && !ld_sec_i) |=> $stable(sec_q));
    // R2
    sec_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && !ld_sec_i && sec_q == SEC_LAST) |=> (sec_q == 6'd0));
endmodule

// File: rtl/rtc_alarm_irq.sv
// rtc_alarm_irq: alarm registers and compare, sticky status flags with
// write-one-to-clear, enable mask and interrupt output. The alarm is
// compared only in the cycle after a seconds update. Assumes SUB_W <= 9
// so that the sample flags fit in bits 8..15.
module rtc_alarm_irq
    import rtc_pkg::*;
#(
    parameter int DAY_W  = 16,
    parameter int STAT_W = 16,
    parameter int SUB_W  = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SUB_W:0]    rate_tick_i,
    input  tod_t              tod_i,
    input  logic [DAY_W-1:0]  day_i,
    input  logic              ld_ahm_i,
    input  logic              ld_asec_i,
    input  logic              ld_aday_i,
    input  tod_t              load_i,
    input  logic [DAY_W-1:0]  day_d_i,
    input  logic              stat_wr_i,
    input  logic              ien_wr_i,
    input  logic [STAT_W-1:0] wdata_i,
    output tod_t              alarm_o,
    output logic [DAY_W-1:0]  aday_o,
    output logic [STAT_W-1:0] status_o,
    output logic [STAT_W-1:0] ien_o,
    output logic              irq_o
);
    tod_t              alarm_q;
    logic [DAY_W-1:0]  aday_q;
    logic [STAT_W-1:0] status_q, ien_q, set_vec, clr_vec;
    logic              upd_q, match;

    // Alarm registers, loaded field by field from the bus.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            alarm_q <= '0;
            aday_q  <= '0;
        end else begin
            if (ld_ahm_i) begin
                alarm_q.hour <= load_i.hour;
                alarm_q.min  <= load_i.min;
            end
            if (ld_asec_i) alarm_q.sec <= load_i.sec;
            if (ld_aday_i) aday_q <= day_d_i;
        end
    end

    // Mark the cycle right after the time counters stepped.
    always_ff @(posedge clk) begin
        if (!rst_n) upd_q <= 1'b0;
        else        upd_q <= rate_tick_i[0];
    end

    assign match = (tod_i == alarm_q) && (day_i == aday_q);

    // Gather this cycle's events into the status bit layout.
    always_comb begin
        set_vec             = '0;
        set_vec[STAT_ALARM] = upd_q && match;
        set_vec[STAT_1HZ]   = rate_tick_i[0];
        set_vec[STAT_2HZ]   = rate_tick_i[1];
        for (int k = 2; k <= SUB_W; k++) begin
            set_vec[STAT_SAMPLE_LO + k - 2] = rate_tick_i[k];
        end
    end

    assign clr_vec = stat_wr_i ? wdata_i : '0;

    // Sticky flags; a new event beats a same-cycle clear.
    always_ff @(posedge clk) begin
        if (!rst_n) status_q <= '0;
        else        status_q <= (status_q & ~clr_vec) | set_vec;
    end

    // Interrupt enable mask.
    always_ff @(posedge clk) begin
        if (!rst_n)        ien_q <= '0;
        else if (ien_wr_i) ien_q <= wdata_i;
    end

    assign irq_o    = |(status_q & ien_q);
    assign alarm_o  = alarm_q;
    assign aday_o   = aday_q;
    assign status_o = status_q;
    assign ien_o    = ien_q;

    // R9
    alarm_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status_q[STAT_ALARM]) |-> $past(upd_q));
    // R7
    status_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_wr_i && set_vec == '0) |=> ((status_q & $past(wdata_i)) == '0));
endmodule

// File: rtl/rtc_core.sv
// rtc_core: top of the RTC. Decodes the byte-offset register port,
// holds the control register, and wires the prescaler, time counters
// and alarm/interrupt logic. Assumes clk is the reference clock itself
// and that DATA_W is 16.
module rtc_core
    import rtc_pkg::*;
#(
    parameter int DIV_A  = 32768,
    parameter int DIV_B  = 32000,
    parameter int DIV_C  = 38400,
    parameter int SUB_W  = 9,
    parameter int ADDR_W = 6,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq_o
);
    localparam int DAY_W = DATA_W;

    logic [2:0]       ctrl_q;
    logic             wr_hm, wr_sec, wr_day, wr_ctrl, wr_ahm, wr_asec, wr_aday;
    logic             wr_stat, wr_ien, restart;
    logic [SUB_W:0]   rate_tick;
    tod_t             tod, alarm, load;
    logic [DAY_W-1:0] day, aday;
    logic [DATA_W-1:0] status, ien;

    assign wr_hm   = bus_we && (bus_addr == ADDR_W'(OFS_HM));
    assign wr_sec  = bus_we && (bus_addr == ADDR_W'(OFS_SEC));
    assign wr_day  = bus_we && (bus_addr == ADDR_W'(OFS_DAY));
    assign wr_ahm  = bus_we && (bus_addr == ADDR_W'(OFS_AHM));
    assign wr_asec = bus_we && (bus_addr == ADDR_W'(OFS_ASEC));
    assign wr_aday = bus_we && (bus_addr == ADDR_W'(OFS_ADAY));
    assign wr_ctrl = bus_we && (bus_addr == ADDR_W'(OFS_CTRL));
    assign wr_stat = bus_we && (bus_addr == ADDR_W'(OFS_STAT));
    assign wr_ien  = bus_we && (bus_addr == ADDR_W'(OFS_IEN));
    assign restart = wr_hm || wr_sec || wr_day || wr_ctrl;

    assign load = '{hour: bus_wdata[12:8], min: bus_wdata[5:0], sec: bus_wdata[5:0]};

    // Control register: run enable (bit 7) and rate select (bits 6:5).
    always_ff @(posedge clk) begin
        if (!rst_n)       ctrl_q <= '0;
        else if (wr_ctrl) ctrl_q <= bus_wdata[7:5];
    end

    rtc_prescaler #(
        .DIV_A(DIV_A), .DIV_B(DIV_B), .DIV_C(DIV_C), .SUB_W(SUB_W)
    ) u_presc (
        .clk(clk), .rst_n(rst_n), .en_i(ctrl_q[2]), .restart_i(restart),
        .sel_i(ctrl_q[1:0]), .rate_tick_o(rate_tick)
    );

    rtc_timekeeper #(.DAY_W(DAY_W)) u_time (
        .clk(clk), .rst_n(rst_n), .tick_i(rate_tick[0]),
        .ld_sec_i(wr_sec), .ld_hm_i(wr_hm), .ld_day_i(wr_day),
        .load_i(load), .day_d_i(bus_wdata), .tod_o(tod), .day_o(day)
    );

    rtc_alarm_irq #(.DAY_W(DAY_W), .STAT_W(DATA_W), .SUB_W(SUB_W)) u_alarm (
        .clk(clk), .rst_n(rst_n), .rate_tick_i(rate_tick),
        .tod_i(tod), .day_i(day),
        .ld_ahm_i(wr_ahm), .ld_asec_i(wr_asec), .ld_aday_i(wr_aday),
        .load_i(load), .day_d_i(bus_wdata),
        .stat_wr_i(wr_stat), .ien_wr_i(wr_ien), .wdata_i(bus_wdata),
        .alarm_o(alarm), .aday_o(aday), .status_o(status), .ien_o(ien),
        .irq_o(irq_o)
    );

    // Read multiplexer; unmapped offsets return zero.
    always_comb begin
        case (bus_addr)
            ADDR_W'(OFS_HM):   bus_rdata = {3'b0, tod.hour, 2'b0, tod.min};
            ADDR_W'(OFS_SEC):  bus_rdata = {10'b0, tod.sec};
            ADDR_W'(OFS_AHM):  bus_rdata = {3'b0, alarm.hour, 2'b0, alarm.min};
            ADDR_W'(OFS_ASEC): bus_rdata = {10'b0, alarm.sec};
            ADDR_W'(OFS_CTRL): bus_rdata = {8'b0, ctrl_q, 5'b0};
            ADDR_W'(OFS_STAT): bus_rdata = status;
            ADDR_W'(OFS_IEN):  bus_rdata = ien;
            ADDR_W'(OFS_DAY):  bus_rdata = day;
            ADDR_W'(OFS_ADAY): bus_rdata = aday;
            default:           bus_rdata = '0;
        endcase
    end

    // R4
    frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl_q[2] && !bus_we) |=> $stable(tod));
endmodule

// File: tb/rtc_core_tb_top.sv
// Bench for rtc_core: register table loop, then directed timing tests.
module rtc_core_tb_top;
    localparam int DIV_A = 32768;
    localparam int DIV_B = 32000;
    localparam int DIV_C = 38400;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        bus_we;
    logic [5:0]  bus_addr;
    logic [15:0] bus_wdata;
    logic [15:0] bus_rdata;
    logic        irq_o;
    int          checks = 0;
    int          fails  = 0;
    logic [15:0] rv;

    always #10 clk = ~clk;

    rtc_core dut_i (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_o(irq_o)
    );

    // {offset, write data, expected readback}
    localparam logic [37:0] VEC [15] = '{
        {6'h10, 16'h0060, 16'h0060},
        {6'h10, 16'h00FF, 16'h00E0},
        {6'h10, 16'h0000, 16'h0000},
        {6'h04, 16'h002A, 16'h002A},
        {6'h04, 16'hFFFF, 16'h003F},
        {6'h00, 16'h1734, 16'h1734},
        {6'h00, 16'hFFFF, 16'h1F3F},
        {6'h20, 16'hBEEF, 16'hBEEF},
        {6'h08, 16'h0C1E, 16'h0C1E},
        {6'h0C, 16'h002D, 16'h002D},
        {6'h24, 16'h1234, 16'h1234},
        {6'h18, 16'hA5A5, 16'hA5A5},
        {6'h1C, 16'hFFFF, 16'h0000},
        {6'h28, 16'hFFFF, 16'h0000},
        {6'h14, 16'hFFFF, 16'h0000}
    };

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Called at a negedge; the write lands on the next posedge.
    task automatic wr(input logic [5:0] a, input logic [15:0] d);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [15:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        rst_n = 1'b0; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0;
        step(3);
        // Reset state
        rd(6'h10, rv); chk("R4 reset ctrl", rv, 16'h0000);
        rd(6'h14, rv); chk("R7 reset status", rv, 16'h0000);
        rd(6'h04, rv); chk("R2 reset seconds", rv, 16'h0000);
        chk("R8 reset irq", {15'b0, irq_o}, 16'h0000);
        rst_n = 1'b1;
        step(1);

        // R1 R10 register table, counting disabled
        for (int i = 0; i < 15; i++) begin
            wr(VEC[i][37:32], VEC[i][31:16]);
            rd(VEC[i][37:32], rv);
            chk($sformatf("R1/R10 table entry %0d", i), rv, VEC[i][15:0]);
        end
        wr(6'h18, 16'h0000);

        // R4 disabled: nothing moves
        wr(6'h04, 16'h0005);
        step(1000);
        rd(6'h04, rv); chk("R4 seconds frozen", rv, 16'h0005);
        rd(6'h14, rv); chk("R4 no flags while disabled", rv, 16'h0000);

        // R6 R8 fast flags after restart, 32768 mode
        wr(6'h10, 16'h0080);
        wr(6'h04, 16'h0000);
        step(63);
        rd(6'h14, rv); chk("R6 no 512Hz flag before edge 64", rv, 16'h0000);
        step(1);
        rd(6'h14, rv); chk("R6 512Hz flag at edge 64", rv, 16'h8000);
        chk("R8 masked flag no irq", {15'b0, irq_o}, 16'h0000);
        wr(6'h18, 16'h8000);
        chk("R8 enabled flag raises irq", {15'b0, irq_o}, 16'h0001);
        wr(6'h14, 16'h8000);
        rd(6'h14, rv); chk("R7 w1c clears bit 15", rv, 16'h0000);
        chk("R8 irq drops after clear", {15'b0, irq_o}, 16'h0000);
        step(62);
        rd(6'h14, rv); chk("R6 256Hz and 512Hz at edge 128", rv, 16'hC000);
        chk("R8 irq again", {15'b0, irq_o}, 16'h0001);
        wr(6'h18, 16'h0000);
        wr(6'h14, 16'hFFFF);

        // R2 R3 R5 full carry, 32768 mode
        wr(6'h00, 16'h173B);
        wr(6'h20, 16'h0005);
        wr(6'h04, 16'h003B);
        step(DIV_A - 1);
        rd(6'h04, rv); chk("R5 seconds unchanged one clock early", rv, 16'h003B);
        step(1);
        rd(6'h04, rv); chk("R2 seconds wrap", rv, 16'h0000);
        rd(6'h00, rv); chk("R2 hour/minute wrap", rv, 16'h0000);
        rd(6'h20, rv); chk("R2 day carry", rv, 16'h0006);
        rd(6'h14, rv); chk("R6 1Hz and 2Hz flags", rv & 16'h00FF, 16'h0090);

        // R9 alarm
        wr(6'h24, 16'h0006);
        wr(6'h08, 16'h0000);
        wr(6'h0C, 16'h0001);
        wr(6'h14, 16'hFFFF);
        wr(6'h04, 16'h0000);
        step(DIV_A);
        rd(6'h04, rv); chk("R3 seconds step in 32768 mode", rv, 16'h0001);
        rd(6'h14, rv); chk("R9 alarm not yet set", rv & 16'h0004, 16'h0000);
        step(1);
        rd(6'h14, rv); chk("R9 alarm set one edge later", rv & 16'h0004, 16'h0004);
        wr(6'h14, 16'h0004);
        step(20);
        rd(6'h14, rv); chk("R9 alarm stays clear", rv & 16'h0004, 16'h0000);

        // R3 32000 mode
        wr(6'h10, 16'h00A0);
        wr(6'h04, 16'h000A);
        step(DIV_B - 1);
        rd(6'h04, rv); chk("R3 32000 mode early", rv, 16'h000A);
        step(1);
        rd(6'h04, rv); chk("R3 32000 mode step", rv, 16'h000B);

        // R3 R2 38400 mode with minute carry
        wr(6'h10, 16'h00C0);
        wr(6'h00, 16'h0105);
        wr(6'h04, 16'h003B);
        step(DIV_C - 1);
        rd(6'h04, rv); chk("R3 38400 mode early", rv, 16'h003B);
        step(1);
        rd(6'h04, rv); chk("R3 38400 mode wrap", rv, 16'h0000);
        rd(6'h00, rv); chk("R2 minute carry", rv, 16'h0106);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule